// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block holds a bank of general-purpose event counters, four by default, behind a small register interface. Each counter is 64 bits wide and watches one source. The source is set by an event code and can be one of the one-cycle hardware event pulses, a software increment strobe, or, for an odd counter, the 32-bit overflow of the even counter directly below it. A control register holds a global enable, a self-clearing command that zeroes every counter, and a mode bit that picks where overflow is flagged: on the carry out of bit 31 or on the carry out of bit 63. The counter value keeps counting into its upper half in both modes.

An overflow sets a sticky status bit that software clears by writing ones. A level interrupt is raised while any status bit has its interrupt-enable bit set. The per-counter enables and the interrupt enables each have their own set address and their own clear address. Reads are combinational from `reg_addr`. Writes take effect on the clock edge where `reg_wr` is high.

Register map (byte-free word addresses): 0x00 control, 0x01 enable-set, 0x02 enable-clear, 0x03 software increment, 0x04 overflow status, 0x05 interrupt-enable-set, 0x06 interrupt-enable-clear, 0x10+i value of counter i, 0x20+i event code of counter i. Event codes are 0x00 software increment, 0x01 chain, and 0x02+k hardware event input k. Any other code counts nothing. Control bits: 0 global enable, 1 clear-all-counters command, 2 cycle-counter clear command (no effect here), 4 and 5 stored spare flags, 6 long-cycle flag, 7 64-bit overflow mode, and 15:11 the read-only number of counters.

Top module: `evcnt_bank`

## Requirements
- R1: Every counter holds 64 bits and carries from bit 31 into bit 32 in both overflow modes (0xFFFFFFF0 plus 100 steps reads 0x100000054).
- R2: With control bit 7 clear, overflow is flagged on the carry out of bit 31. With it set, overflow is flagged only on the carry out of bit 63, and a bit-31 carry flags nothing.
- R3: Writing a mask to address 0x03 advances each selected counter by one when it has code 0x00, its enable bit set and control bit 0 set. Nothing advances while control bit 0 is clear.
- R4: With control bit 7 clear, an odd counter with code 0x01 advances by one on every bit-31 carry of the even counter below it. When both overflow, status bits for both are set.
- R5: With control bit 7 set, a chained counter never advances. An even-counter overflow then sets only the even status bit, even when the odd counter holds all ones.
- R6: Overflow status bits are sticky and are cleared only by writing ones to address 0x04.
- R7: `irq` is high exactly while some status bit has its interrupt-enable bit set. Status stays set with `irq` low when no enable is set. Enables are set at 0x05 and cleared at 0x06.
- R8: Counter enables are set by writing ones at 0x01 and cleared by writing ones at 0x02. A counter with a clear enable does not advance.
- R9: Writing control bit 1 zeroes every counter. Bits 1 and 2 read back as zero, bits 0, 4 to 7 keep their written values, and bits 15:11 read the counter count.
- R10: A register write to a counter wins over an increment in the same cycle, and the write never sets an overflow status bit.
- R11: After reset all counters, enables, codes, status and control bits are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| evt_in | input | NUM_EVT | One-cycle hardware event pulses, one per event type |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that each counter is written through its own address only and never in the same cycle as a clear-all command, which holds because one address is decoded per cycle. They also take the event inputs as plain pulses with no relation to register writes. The directed stimulus writes one register per two cycles and drives event pulses one cycle wide, so every increment is visible to the one-step and sticky-status properties. The single case where a write and an event meet in one cycle is placed deliberately to check the priority rule.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int CW = 64;
  localparam int TW = 8;

  typedef logic [CW-1:0] cnt_t;
  typedef logic [TW-1:0] evt_code_t;

  localparam evt_code_t CODE_SW      = 8'h00;
  localparam evt_code_t CODE_CHAIN   = 8'h01;
  localparam evt_code_t CODE_HW_BASE = 8'h02;

  localparam logic [7:0] A_CTRL      = 8'h00;
  localparam logic [7:0] A_ENSET     = 8'h01;
  localparam logic [7:0] A_ENCLR     = 8'h02;
  localparam logic [7:0] A_SWINC     = 8'h03;
  localparam logic [7:0] A_OVF       = 8'h04;
  localparam logic [7:0] A_IESET     = 8'h05;
  localparam logic [7:0] A_IECLR     = 8'h06;
  localparam logic [7:0] A_CNT_BASE  = 8'h10;
  localparam logic [7:0] A_TYPE_BASE = 8'h20;

  localparam int B_EN  = 0;
  localparam int B_CLR = 1;
  localparam int B_X   = 4;
  localparam int B_DP  = 5;
  localparam int B_LC  = 6;
  localparam int B_LP  = 7;
  localparam int B_N   = 11;

  // carry leaves the selected boundary on the next +1
  function automatic logic crosses_at(input cnt_t v, input logic wide);
    return wide ? (&v) : (&v[31:0]);
  endfunction

  function automatic logic carry_lo(input cnt_t v);
    return &v[31:0];
  endfunction

  function automatic cnt_t step(input cnt_t v);
    return v + cnt_t'(1);
  endfunction
endpackage

// File: rtl/evcnt_slice.sv
module evcnt_slice
  import evcnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cnt_t wdata,
  input  logic clr,
  input  logic inc,
  input  logic wide,
  output cnt_t cnt,
  output logic ovf_evt,
  output logic carry32
);
  logic step_ok;
  assign step_ok = inc && !wr && !clr;
  assign ovf_evt = step_ok && crosses_at(cnt, wide);
  assign carry32 = step_ok && carry_lo(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (wr)      cnt <= wdata;
    else if (clr)     cnt <= '0;
    else if (inc)     cnt <= step(cnt);
  end
endmodule

// File: rtl/evcnt_src.sv
module evcnt_src
  import evcnt_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter bit ODD     = 1'b0
) (
  input  evt_code_t          code,
  input  logic               sw_bit,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               chain_in,
  input  logic               run,
  input  logic               wide,
  output logic               inc,
  output logic               chain_inc
);
  logic hw_hit;
  logic chain_ok;

  always_comb begin
    hw_hit = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (code == evt_code_t'(CODE_HW_BASE + k)) hw_hit = evt_in[k];
    end
  end

  assign chain_ok  = ODD && (code == CODE_CHAIN) && !wide;
  assign chain_inc = run && chain_ok && chain_in;
  assign inc       = run && (((code == CODE_SW) && sw_bit) || hw_hit || (chain_ok && chain_in));
endmodule

// File: rtl/evcnt_regs.sv
module evcnt_regs
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [7:0]            reg_addr,
  input  logic [15:0]           wdata_lo,
  input  logic [NUM_CNT-1:0]    ovf_evt,
  output logic                  glob_en,
  output logic                  wide,
  output logic [CW-1:0]         ctrl_rd,
  output logic [NUM_CNT-1:0]    en_q,
  output logic [NUM_CNT-1:0]    ien_q,
  output logic [NUM_CNT-1:0]    ovf_q,
  output logic [NUM_CNT-1:0]    w1c_mask,
  output logic [NUM_CNT-1:0]    sw_pulse,
  output logic                  clr_all,
  output logic [NUM_CNT-1:0]    cnt_wr,
  output logic [NUM_CNT*TW-1:0] code_flat
);
  localparam logic [4:0] NFIELD = 5'(NUM_CNT);

  logic hit_ctrl, hit_enset, hit_enclr, hit_sw, hit_ovf, hit_ieset, hit_ieclr;
  logic f_x, f_dp, f_lc;
  logic [NUM_CNT-1:0] wmask;
  logic unused_bits;

  assign wmask     = wdata_lo[NUM_CNT-1:0];
  assign hit_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign hit_enset = reg_wr && (reg_addr == A_ENSET);
  assign hit_enclr = reg_wr && (reg_addr == A_ENCLR);
  assign hit_sw    = reg_wr && (reg_addr == A_SWINC);
  assign hit_ovf   = reg_wr && (reg_addr == A_OVF);
  assign hit_ieset = reg_wr && (reg_addr == A_IESET);
  assign hit_ieclr = reg_wr && (reg_addr == A_IECLR);

  assign sw_pulse  = hit_sw  ? wmask : '0;
  assign w1c_mask  = hit_ovf ? wmask : '0;
  assign clr_all   = hit_ctrl && wdata_lo[B_CLR];
  assign unused_bits = ^{wdata_lo[15:8], wdata_lo[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      wide    <= 1'b0;
      f_x     <= 1'b0;
      f_dp    <= 1'b0;
      f_lc    <= 1'b0;
      en_q    <= '0;
      ien_q   <= '0;
      ovf_q   <= '0;
    end else begin
      if (hit_ctrl) begin
        glob_en <= wdata_lo[B_EN];
        f_x     <= wdata_lo[B_X];
        f_dp    <= wdata_lo[B_DP];
        f_lc    <= wdata_lo[B_LC];
        wide    <= wdata_lo[B_LP];
      end
      if (hit_enset) en_q  <= en_q | wmask;
      if (hit_enclr) en_q  <= en_q & ~wmask;
      if (hit_ieset) ien_q <= ien_q | wmask;
      if (hit_ieclr) ien_q <= ien_q & ~wmask;
      ovf_q <= (ovf_q & ~w1c_mask) | ovf_evt;
    end
  end

  always_comb begin
    ctrl_rd        = '0;
    ctrl_rd[B_EN]  = glob_en;
    ctrl_rd[B_X]   = f_x;
    ctrl_rd[B_DP]  = f_dp;
    ctrl_rd[B_LC]  = f_lc;
    ctrl_rd[B_LP]  = wide;
    ctrl_rd[B_N +: 5] = NFIELD;
  end

  genvar i;
  generate
    for (i = 0; i < NUM_CNT; i++) begin : g_code
      logic hit_code;
      assign hit_code = reg_wr && (reg_addr == 8'(A_TYPE_BASE + i));
      assign cnt_wr[i] = reg_wr && (reg_addr == 8'(A_CNT_BASE + i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        code_flat[i*TW +: TW] <= '0;
        else if (hit_code) code_flat[i*TW +: TW] <= wdata_lo[TW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq
);
  logic                  glob_en, wide, clr_all;
  logic [CW-1:0]         ctrl_rd;
  logic [NUM_CNT-1:0]    en_q, ien_q, ovf_q, w1c_mask, sw_pulse, cnt_wr;
  logic [NUM_CNT-1:0]    inc_vec, ovf_evt, carry32, chain_inc;
  logic [NUM_CNT*TW-1:0] code_flat;
  cnt_t                  cnt [NUM_CNT];
  cnt_t                  cnt0_mon;

  evcnt_regs #(.NUM_CNT(NUM_CNT)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata_lo(reg_wdata[15:0]), .ovf_evt(ovf_evt),
    .glob_en(glob_en), .wide(wide), .ctrl_rd(ctrl_rd),
    .en_q(en_q), .ien_q(ien_q), .ovf_q(ovf_q), .w1c_mask(w1c_mask),
    .sw_pulse(sw_pulse), .clr_all(clr_all), .cnt_wr(cnt_wr),
    .code_flat(code_flat)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_CNT; i++) begin : g_cnt
      logic chain_in;
      if ((i % 2) == 1) begin : g_odd
        assign chain_in = carry32[i-1];
      end else begin : g_even
        assign chain_in = 1'b0;
      end

      evcnt_src #(.NUM_EVT(NUM_EVT), .ODD((i % 2) == 1)) src_i (
        .code(code_flat[i*TW +: TW]), .sw_bit(sw_pulse[i]), .evt_in(evt_in),
        .chain_in(chain_in), .run(glob_en && en_q[i]), .wide(wide),
        .inc(inc_vec[i]), .chain_inc(chain_inc[i])
      );

      evcnt_slice slice_i (
        .clk(clk), .rst_n(rst_n), .wr(cnt_wr[i]), .wdata(reg_wdata),
        .clr(clr_all), .inc(inc_vec[i]), .wide(wide),
        .cnt(cnt[i]), .ovf_evt(ovf_evt[i]), .carry32(carry32[i])
      );
    end
  endgenerate

  assign cnt0_mon = cnt[0];
  assign irq      = |(ovf_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:           reg_rdata = ctrl_rd;
      A_ENSET, A_ENCLR: reg_rdata = 64'(en_q);
      A_OVF:            reg_rdata = 64'(ovf_q);
      A_IESET, A_IECLR: reg_rdata = 64'(ien_q);
      default:          reg_rdata = '0;
    endcase
    for (int k = 0; k < NUM_CNT; k++) begin
      if (reg_addr == 8'(A_CNT_BASE + k))  reg_rdata = cnt[k];
      if (reg_addr == 8'(A_TYPE_BASE + k)) reg_rdata = 64'(code_flat[k*TW +: TW]);
    end
  end
endmodule

// File: rtl/evcnt_bank_chk.sv
module evcnt_bank_chk #(
  parameter int NUM_CNT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glob_en,
  input logic               wide,
  input logic               clr_all,
  input logic               irq,
  input logic [NUM_CNT-1:0] ien_q,
  input logic [NUM_CNT-1:0] ovf_q,
  input logic [NUM_CNT-1:0] w1c_mask,
  input logic [NUM_CNT-1:0] cnt_wr,
  input logic [NUM_CNT-1:0] inc_vec,
  input logic [NUM_CNT-1:0] ovf_evt,
  input logic [NUM_CNT-1:0] chain_inc,
  input logic [63:0]        cnt0_mon
);
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ovf_q) & ~$past(w1c_mask)) & ~ovf_q) == '0)); // R6

  AST_WRITE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr & ovf_evt) == '0); // R10

  AST_CHAIN_IDLE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> (chain_inc == '0)); // R5

  AST_HALT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> (inc_vec == '0)); // R3

  AST_IRQ_HAS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ovf_q & ien_q) != '0)); // R7

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr[0] && !clr_all) |=> ((cnt0_mon == $past(cnt0_mon)) ||
                                  (cnt0_mon == $past(cnt0_mon) + 64'd1))); // R1
endmodule

bind evcnt_bank evcnt_bank_chk #(.NUM_CNT(NUM_CNT)) chk_i (
  .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .wide(wide), .clr_all(clr_all),
  .irq(irq), .ien_q(ien_q), .ovf_q(ovf_q), .w1c_mask(w1c_mask), .cnt_wr(cnt_wr),
  .inc_vec(inc_vec), .ovf_evt(ovf_evt), .chain_inc(chain_inc), .cnt0_mon(cnt0_mon)
);

// File: tb/evcnt_bank_tb_top.sv
`timescale 1ns/1ps
module evcnt_bank_tb_top;
  localparam int NC = 4;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic [NE-1:0] evt_in = '0;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  evcnt_bank #(.NUM_CNT(NC), .NUM_EVT(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rchk(input string req, input string what, input logic [7:0] a, input logic [63:0] exp);
    logic [63:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic pulse(input int k, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); evt_in[k] = 1'b1;
      @(negedge clk); evt_in[k] = 1'b0;
    end
  endtask

  task automatic sw_burst(input logic [63:0] m, input int n);
    for (int j = 0; j < n; j++) wr(8'h03, m);
  endtask

  task automatic t_reset;
    rchk("R11", "ctrl", 8'h00, 64'h2000);
    rchk("R11", "cnt0", 8'h10, 64'h0);
    rchk("R11", "code3", 8'h23, 64'h0);
    rchk("R11", "status", 8'h04, 64'h0);
    rchk("R11", "enable", 8'h01, 64'h0);
    chk("R11", "irq", 64'(irq), 64'h0);
  endtask

  task automatic t_sw_halted;
    wr(8'h10, 64'hFFFF_FFF0);
    wr(8'h01, 64'h3);
    sw_burst(64'h3, 100);
    rchk("R3", "cnt0 halted", 8'h10, 64'hFFFF_FFF0);
    rchk("R3", "cnt1 halted", 8'h11, 64'h0);
    rchk("R3", "status halted", 8'h04, 64'h0);
  endtask

  task automatic t_sw_run;
    wr(8'h00, 64'h1);
    sw_burst(64'h3, 100);
    rchk("R1", "cnt0 carries past bit31", 8'h10, 64'h1_0000_0054);
    rchk("R3", "cnt1 100 steps", 8'h11, 64'd100);
    rchk("R2", "status 32-bit mode", 8'h04, 64'h1);
    chk("R7", "irq masked", 64'(irq), 64'h0);
  endtask

  task automatic t_irq;
    wr(8'h05, 64'h1);
    chk("R7", "irq raised", 64'(irq), 64'h1);
    wr(8'h04, 64'h2);
    rchk("R6", "status kept on other w1c", 8'h04, 64'h1);
    wr(8'h04, 64'h1);
    rchk("R6", "status cleared", 8'h04, 64'h0);
    chk("R7", "irq dropped", 64'(irq), 64'h0);
    wr(8'h06, 64'h1);
    rchk("R7", "ien cleared", 8'h05, 64'h0);
  endtask

  task automatic t_wide;
    wr(8'h00, 64'hC7);
    rchk("R9", "ctrl readback", 8'h00, 64'h20C1);
    rchk("R9", "cnt1 cleared", 8'h11, 64'h0);
    wr(8'h10, 64'hFFFF_FFFF_FFFF_FFF0);
    wr(8'h11, 64'hFFFF_FFF0);
    sw_burst(64'h3, 100);
    rchk("R2", "cnt0 wraps at 64", 8'h10, 64'h54);
    rchk("R1", "cnt1 wide mode", 8'h11, 64'h1_0000_0054);
    rchk("R2", "status only 64-bit carry", 8'h04, 64'h1);
    wr(8'h04, 64'hF);
  endtask

  task automatic t_chain;
    wr(8'h00, 64'h1);
    wr(8'h20, 64'h2);
    wr(8'h21, 64'h1);
    wr(8'h10, 64'hFFFF_FFF0);
    wr(8'h11, 64'h0);
    pulse(0, 20);
    rchk("R4", "even cnt", 8'h10, 64'h1_0000_0004);
    rchk("R4", "odd chained cnt", 8'h11, 64'h1);
    rchk("R4", "status even", 8'h04, 64'h1);
    wr(8'h04, 64'hF);
    wr(8'h10, 64'hFFFF_FFF0);
    wr(8'h11, 64'hFFFF_FFFF);
    pulse(0, 20);
    rchk("R4", "odd carries", 8'h11, 64'h1_0000_0000);
    rchk("R4", "status both", 8'h04, 64'h3);
    wr(8'h04, 64'hF);
  endtask

  task automatic t_chain_wide;
    wr(8'h00, 64'h81);
    wr(8'h10, 64'hFFFF_FFFF_FFFF_FFF0);
    wr(8'h11, 64'hFFFF_FFFF_FFFF_FFFF);
    pulse(0, 20);
    rchk("R5", "even wraps", 8'h10, 64'h4);
    rchk("R5", "odd idle", 8'h11, 64'hFFFF_FFFF_FFFF_FFFF);
    rchk("R5", "status even only", 8'h04, 64'h1);
    wr(8'h04, 64'hF);
  endtask

  task automatic t_enable;
    wr(8'h00, 64'h1);
    wr(8'h21, 64'h3);
    wr(8'h11, 64'h0);
    wr(8'h02, 64'h2);
    rchk("R8", "enable after clear", 8'h01, 64'h1);
    pulse(1, 5);
    rchk("R8", "disabled idle", 8'h11, 64'h0);
    wr(8'h01, 64'h2);
    pulse(1, 5);
    rchk("R8", "re-enabled counts", 8'h11, 64'h5);
  endtask

  task automatic t_write_prio;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 64'hFFFF_FFFF; evt_in[0] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_in[0] = 1'b0;
    rchk("R10", "write wins", 8'h10, 64'hFFFF_FFFF);
    rchk("R10", "no flag on write", 8'h04, 64'h0);
    pulse(0, 1);
    rchk("R10", "step after write", 8'h10, 64'h1_0000_0000);
    rchk("R2", "flag on step", 8'h04, 64'h1);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_sw_halted;
    t_sw_run;
    t_irq;
    t_wide;
    t_chain;
    t_chain_wide;
    t_enable;
    t_write_prio;
    done = 1'b1;
    finish_run;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run;
    end
  end
endmodule